// File: doc/BRIEF.md
# Return Address Stack with Interrupt Gating

This block keeps the return addresses of a small microcontroller core. A subroutine call, or an interrupt that the block grants, saves the current program counter. A return instruction restores the most recent saved value. The stack has a fixed number of levels, eight by default. It is invisible to software: neither the entries nor the pointer can be read or written. The core drives one strobe for a call and one for a return. The top entry is always visible on `pc_o`, so the core loads it in the same cycle that it issues the return strobe.

An interrupt request that has already been masked arrives on `irq_req_i` and is latched. The grant `irq_ack_o` is withheld while every level is occupied, so taking the interrupt can never overflow the stack. A return frees a level, and after that return the held request is granted. A call on a full stack is not held back. It overwrites the oldest entry, so only the most recent DEPTH return addresses survive.

Two state machines drive the behaviour. The occupancy machine has the states OCC_EMPTY, OCC_PARTIAL and OCC_FULL, with these transitions:
- FIRST_PUSH goes from empty to partial.
- FILL goes from partial to full on the push that takes the last free level.
- DRAIN goes from partial to empty when the last entry is popped.
- RELEASE goes from full to partial on a pop.
- OVERWRITE stays in full on a push.
- UNDERRUN stays in empty on a pop, which is ignored.

The interrupt gate has the states GATE_IDLE and GATE_PEND, with these transitions:
- ARM goes from idle to pending on a request.
- HOLD stays in pending while the grant is blocked.
- GRANT goes from pending to idle when the acknowledge fires.
- REARM stays in pending when a new request arrives in the grant cycle.

Top module: `ret_addr_stack`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, `full_o` and `irq_ack_o` are both 0 and the stack is empty.
- R2: A cycle with `call_i`=1 and `ret_i`=0 stores `pc_i`. From the next cycle on, `pc_o` shows that value as the top entry.
- R3: In a cycle with `ret_i`=1 on a non-empty stack, `pc_o` carries the most recently stored entry, and that entry is removed at the clock edge. Successive returns yield the entries in reverse order of storage.
- R4: `full_o` is 1 exactly when DEPTH entries are stored (DEPTH=8 by default). After a return on a full stack, `full_o` goes to 0 in the next cycle.
- R5: A call on a full stack overwrites the oldest entry and `full_o` stays 1. The DEPTH returns that follow yield the DEPTH most recent values, newest first.
- R6: A cycle with `irq_req_i`=1 latches a request. In the next cycle, if the stack is not full and neither strobe is active, `irq_ack_o` is 1 for that cycle and `pc_i` is stored as with a call.
- R7: While `full_o` is 1, `irq_ack_o` stays 0 and a latched request is kept.
- R8: A held request is granted in the first cycle after a return has freed a level, provided neither strobe is active in that cycle.
- R9: In a cycle where `call_i` or `ret_i` is 1, `irq_ack_o` is 0. A latched request is granted in the first later cycle that has neither strobe and has room on the stack.
- R10: A return on an empty stack is ignored: the stack stays empty, and a later call followed by a return returns the called value.
- R11: If `call_i` and `ret_i` are both 1, the return is performed and the call is ignored. Calling both at once is a protocol error of the core.
- R12: Each latched request yields a single grant. If no new request arrives, `irq_ack_o` is 0 in the cycle after a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Subroutine call strobe: store `pc_i` |
| ret_i | input | 1 | Return strobe: remove the top entry |
| irq_req_i | input | 1 | Masked interrupt request, latched while high |
| pc_i | input | PC_W | Program counter value to store |
| pc_o | output | PC_W | Top entry (the restore value) |
| full_o | output | 1 | All DEPTH levels occupied |
| irq_ack_o | output | 1 | Interrupt grant; also stores `pc_i` |

## Verification
The bench builds the block with the default DEPTH of 8 and a 12-bit program counter. With eight levels, a ninth call and the overwrite of the oldest entry are reached in a few cycles. The test then unwinds the whole stack to confirm that exactly the eight newest values survive. The small depth also makes it cheap to fill the stack, hold an interrupt across several cycles, release it with one return, and then exercise the cycles where the grant collides with a strobe.

// File: rtl/ras_pkg.sv
package ras_pkg;

    // Occupancy of the return stack
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

    // Interrupt gating
    typedef enum logic {
        GATE_IDLE = 1'b0,
        GATE_PEND = 1'b1
    } gate_state_e;

    // Operation applied to the storage at the next edge
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } stack_op_e;

endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    output stack_op_e        op_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic [PTR_W-1:0] rd_idx_o,
    output logic             full_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(DEPTH - 1);

    occ_state_e       state, state_d;
    logic [CNT_W-1:0] cnt, cnt_d;
    logic [PTR_W-1:0] top, top_d;
    stack_op_e        op;

    function automatic logic [PTR_W-1:0] idx_up(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] idx_down(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST_IDX : p - 1'b1;
    endfunction

    // Pop wins over push; a pop on an empty stack is dropped (UNDERRUN)
    always_comb begin
        if (pop_req) begin
            op = (state == OCC_EMPTY) ? OP_NONE : OP_POP;
        end else if (push_req) begin
            op = OP_PUSH;
        end else begin
            op = OP_NONE;
        end
    end

    // Next state, occupancy and pointer
    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        top_d   = top;
        unique case (state)
            OCC_EMPTY: begin
                if (op == OP_PUSH) begin                  // FIRST_PUSH
                    state_d = (DEPTH == 1) ? OCC_FULL : OCC_PARTIAL;
                    cnt_d   = cnt + 1'b1;
                    top_d   = idx_up(top);
                end
            end
            OCC_PARTIAL: begin
                if (op == OP_PUSH) begin
                    if (cnt == ONE_LEFT) begin            // FILL
                        state_d = OCC_FULL;
                    end
                    cnt_d = cnt + 1'b1;
                    top_d = idx_up(top);
                end else if (op == OP_POP) begin
                    if (cnt == CNT_W'(1)) begin           // DRAIN
                        state_d = OCC_EMPTY;
                    end
                    cnt_d = cnt - 1'b1;
                    top_d = idx_down(top);
                end
            end
            OCC_FULL: begin
                if (op == OP_PUSH) begin                  // OVERWRITE
                    top_d = idx_up(top);
                end else if (op == OP_POP) begin          // RELEASE
                    state_d = (DEPTH == 1) ? OCC_EMPTY : OCC_PARTIAL;
                    cnt_d   = cnt - 1'b1;
                    top_d   = idx_down(top);
                end
            end
            default: begin
                state_d = OCC_EMPTY;
                cnt_d   = '0;
                top_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= OCC_EMPTY;
            cnt   <= '0;
            top   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            top   <= top_d;
        end
    end

    // Outputs
    always_comb begin
        op_o     = op;
        wr_idx_o = top;
        rd_idx_o = idx_down(top);
        full_o   = (state == OCC_FULL);
    end

endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int DEPTH  = 8,
    parameter int PTR_W  = 3,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (wr_en && (wr_idx == PTR_W'(g))) begin
                slot[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == PTR_W'(i)) begin
                rd_data = slot[i];
            end
        end
    end

endmodule

// File: rtl/ras_irq_gate.sv
module ras_irq_gate
    import ras_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req_i,
    input  logic full_i,
    input  logic call_i,
    input  logic ret_i,
    output logic ack_o
);
    gate_state_e state, state_d;
    logic        blocked;
    logic        grant;

    always_comb begin
        blocked = full_i || call_i || ret_i;
        grant   = (state == GATE_PEND) && !blocked;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            GATE_IDLE: begin
                if (irq_req_i) begin                 // ARM
                    state_d = GATE_PEND;
                end
            end
            GATE_PEND: begin
                if (grant && !irq_req_i) begin       // GRANT
                    state_d = GATE_IDLE;
                end                                  // HOLD or REARM otherwise
            end
            default: state_d = GATE_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= GATE_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // Outputs
    always_comb begin
        ack_o = grant;
    end

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
    import ras_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_i,
    input  logic            ret_i,
    input  logic            irq_req_i,
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] pc_o,
    output logic            full_o,
    output logic            irq_ack_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    stack_op_e        op;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_idx;
    logic             full;
    logic             ack;

    ras_irq_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req_i (irq_req_i),
        .full_i    (full),
        .call_i    (call_i),
        .ret_i     (ret_i),
        .ack_o     (ack)
    );

    ras_ctrl #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (call_i || ack),
        .pop_req  (ret_i),
        .op_o     (op),
        .wr_idx_o (wr_idx),
        .rd_idx_o (rd_idx),
        .full_o   (full)
    );

    ras_store #(
        .DEPTH  (DEPTH),
        .PTR_W  (PTR_W),
        .DATA_W (PC_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (op == OP_PUSH),
        .wr_idx  (wr_idx),
        .wr_data (pc_i),
        .rd_idx  (rd_idx),
        .rd_data (pc_o)
    );

    assign full_o    = full;
    assign irq_ack_o = ack;

endmodule

// File: rtl/ret_addr_stack_chk.sv
module ret_addr_stack_chk #(
    parameter int PC_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            call_i,
    input logic            ret_i,
    input logic            irq_req_i,
    input logic [PC_W-1:0] pc_i,
    input logic [PC_W-1:0] pc_o,
    input logic            full_o,
    input logic            irq_ack_o
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!full_o && !irq_ack_o));

    a_r2_call_on_top: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i) |=> (pc_o == $past(pc_i)));

    a_r4_full_released: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && ret_i) |=> !full_o);

    a_r5_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && call_i && !ret_i) |=> full_o);

    a_r6_ack_stores_pc: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |=> (pc_o == $past(pc_i)));

    a_r7_no_ack_full: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !irq_ack_o);

    a_r9_no_ack_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i || ret_i) |-> !irq_ack_o);

    a_r12_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_o && !irq_req_i) |=> !irq_ack_o);

endmodule

bind ret_addr_stack ret_addr_stack_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .call_i    (call_i),
    .ret_i     (ret_i),
    .irq_req_i (irq_req_i),
    .pc_i      (pc_i),
    .pc_o      (pc_o),
    .full_o    (full_o),
    .irq_ack_o (irq_ack_o)
);

// File: tb/ret_addr_stack_test.sv
module ret_addr_stack_test;
    localparam int PC_W   = 12;
    localparam int DEPTH  = 8;
    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            call_i = 1'b0;
    logic            ret_i = 1'b0;
    logic            irq_req_i = 1'b0;
    logic [PC_W-1:0] pc_i = '0;
    logic [PC_W-1:0] pc_o;
    logic            full_o;
    logic            irq_ack_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model
    logic [PC_W-1:0] m_stk [$];
    bit              m_pend = 1'b0;

    // Scoreboard items handed from driver to monitor
    logic [PC_W-1:0] exp_q [$];
    bit              exp_ret = 1'b0;
    bit              exp_ack = 1'b0;
    bit              exp_full = 1'b0;
    bit              chk_on = 1'b0;
    string           cur_tag = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    ret_addr_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .call_i    (call_i),
        .ret_i     (ret_i),
        .irq_req_i (irq_req_i),
        .pc_i      (pc_i),
        .pc_o      (pc_o),
        .full_o    (full_o),
        .irq_ack_o (irq_ack_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, expectations from the model
    task automatic cyc(input bit c, input bit r, input bit q,
                       input logic [PC_W-1:0] pc, input string tag);
        bit a;
        @(posedge clk);
        #1;
        call_i    = c;
        ret_i     = r;
        irq_req_i = q;
        pc_i      = pc;
        cur_tag   = tag;
        a         = m_pend && (m_stk.size() < DEPTH) && !c && !r;
        exp_ack   = a;
        exp_full  = (m_stk.size() == DEPTH);
        exp_ret   = 1'b0;
        if (r) begin
            if (m_stk.size() > 0) begin
                exp_q.push_back(m_stk[$]);
                exp_ret = 1'b1;
                void'(m_stk.pop_back());
            end else begin
                $display("WARN %s return on empty stack, output is don't-care", tag);
            end
        end else if (c || a) begin
            m_stk.push_back(pc);
            if (m_stk.size() > DEPTH) void'(m_stk.pop_front());
        end
        m_pend = q || (m_pend && !a);
        chk_on = 1'b1;
    endtask

    // Monitor: compares at the falling edge
    always @(negedge clk) begin
        if (chk_on) begin
            check(cur_tag, "irq_ack_o", PC_W'(irq_ack_o), PC_W'(exp_ack));
            check(cur_tag, "full_o", PC_W'(full_o), PC_W'(exp_full));
            if (exp_ret && exp_q.size() > 0) begin
                check(cur_tag, "pc_o", pc_o, exp_q.pop_front());
            end
        end
    end

    task automatic idle(input string tag);
        cyc(1'b0, 1'b0, 1'b0, '0, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "full_o in reset", PC_W'(full_o), '0);
        check("R1", "irq_ack_o in reset", PC_W'(irq_ack_o), '0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", "full_o after reset", PC_W'(full_o), '0);
        check("R1", "irq_ack_o after reset", PC_W'(irq_ack_o), '0);

        // R2 / R3: simple nesting
        cyc(1, 0, 0, 12'h101, "R2");
        cyc(1, 0, 0, 12'h2A2, "R2");
        cyc(1, 0, 0, 12'h3F3, "R2");
        cyc(0, 1, 0, '0, "R3");
        cyc(1, 0, 0, 12'h444, "R2");
        cyc(0, 1, 0, '0, "R3");
        cyc(0, 1, 0, '0, "R3");
        cyc(0, 1, 0, '0, "R3");

        // R4 / R5: fill, overflow, unwind
        for (int i = 0; i < DEPTH; i++) cyc(1, 0, 0, PC_W'(12'h500 + i), "R4");
        idle("R4");
        cyc(1, 0, 0, 12'h5FF, "R5");
        idle("R5");
        cyc(0, 1, 0, '0, "R4");
        idle("R4");
        for (int i = 1; i < DEPTH; i++) cyc(0, 1, 0, '0, "R5");

        // R10: return on empty is ignored
        cyc(0, 1, 0, '0, "R10");
        idle("R10");
        cyc(1, 0, 0, 12'h6A6, "R10");
        cyc(0, 1, 0, '0, "R10");
        idle("R10");

        // R6 / R12: grant with room
        cyc(0, 0, 1, 12'h700, "R6");
        cyc(0, 0, 0, 12'h7B7, "R6");
        idle("R12");
        idle("R12");
        cyc(0, 1, 0, '0, "R6");

        // R7 / R8: hold while full, release after a return
        for (int i = 0; i < DEPTH; i++) cyc(1, 0, 0, PC_W'(12'h800 + i), "R7");
        cyc(0, 0, 1, 12'h8F0, "R7");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 12'h8F1, "R7");
        cyc(0, 1, 0, '0, "R8");
        cyc(0, 0, 0, 12'h8C8, "R8");
        idle("R12");
        for (int i = 0; i < DEPTH; i++) cyc(0, 1, 0, '0, "R8");

        // R9: strobes defer the grant
        cyc(0, 0, 1, 12'h900, "R9");
        cyc(1, 0, 0, 12'h901, "R9");
        cyc(0, 1, 0, '0, "R9");
        cyc(0, 0, 0, 12'h9D9, "R9");
        idle("R9");
        cyc(0, 1, 0, '0, "R9");
        cyc(0, 1, 0, '0, "R9");

        // R11: simultaneous call and return, return wins
        cyc(1, 0, 0, 12'hA01, "R11");
        cyc(1, 0, 0, 12'hA02, "R11");
        cyc(1, 1, 0, 12'hAEE, "R11");
        cyc(0, 1, 0, '0, "R11");
        idle("R11");
        cyc(1, 1, 0, 12'hAFF, "R11");
        idle("R11");
        cyc(1, 0, 0, 12'hA33, "R11");
        cyc(0, 1, 0, '0, "R11");
        idle("R11");

        @(posedge clk);
        #1 chk_on = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule